// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a slave on a two-wire serial control bus. It gives a bus master read and write access to a small bank of 16-bit control registers. The block samples the bus clock (SCL) and data (SDA) lines with its own system clock and detects start and stop conditions from them. It answers one device address, chosen by a strap input. It then exchanges a 16-bit register pointer and register words with the master.

The slave never drives SDA high. It only pulls the line low through an output-enable, and an external pull-up supplies the high level. A write carries two pointer bytes followed by any number of data words. A read returns words from the held pointer. Both directions advance the pointer after each word, so bursts are supported. A repeated start placed after the pointer bytes gives a random-access read. A strap input can forbid reads altogether.

The control sequence has six states:
- `ST_IDLE`: the slave ignores clock pulses.
- `ST_RECV`: the slave shifts in one byte.
- `ST_ACK_OUT`: the slave holds SDA low for the acknowledge clock.
- `ST_SEND`: the slave shifts out one byte.
- `ST_ACK_IN`: the slave samples the master's acknowledge.
- `ST_SEND_NEXT`: the slave waits for the clock fall before driving the next byte.

The transitions between them are:
- Any start goes to `ST_RECV` with the address byte expected next. Any stop goes to `ST_IDLE`.
- In `ST_RECV`, the eighth bit followed by a clock fall goes to `ST_ACK_OUT` when the byte is accepted and to `ST_IDLE` when it is refused.
- In `ST_ACK_OUT`, the clock fall goes to `ST_SEND` for a read and back to `ST_RECV` for a write.
- In `ST_SEND`, the clock fall after eight bits goes to `ST_ACK_IN`.
- In `ST_ACK_IN`, a master acknowledge goes to `ST_SEND_NEXT` and a master not-acknowledge goes to `ST_IDLE`.
- In `ST_SEND_NEXT`, the clock fall goes to `ST_SEND`.

Top module: `i2c_regbank_slave`

## Requirements
- R1: After reset the slave releases SDA, every register reads 0x0000 and the register pointer is 0.
- R2: The slave only ever pulls SDA low or releases it, and it changes its SDA drive only after a falling SCL edge.
- R3: The 7-bit device address is 0x34 when `id_sel` is 0 and 0x36 when it is 1, so the write/read bytes are 0x68/0x69 and 0x6C/0x6D. The byte is sent MSB first, and its bit 0 set to 1 requests a read. On a match the slave pulls SDA low during the ninth clock.
- R4: On an address mismatch the slave does not acknowledge and ignores all following bytes until the next start.
- R5: While `wr_only` is 1, a read request is refused like a mismatch and the slave drives nothing on SDA.
- R6: A write transfer is the address byte, the pointer high byte, the pointer low byte, then the data high byte and the data low byte. Each byte is acknowledged, and the register is written when its low byte completes.
- R7: After each written word the pointer advances by one, so further words in the same transfer go to consecutive registers.
- R8: A read returns the register at the pointer, high byte first. Pointer bytes written and then followed by a repeated start and a read address select the register read.
- R9: During a read, a master acknowledge after a byte continues the burst. The pointer advances after each word's low byte, and a master not-acknowledge ends the read.
- R10: A stop returns the slave to idle at any point. A start at any point restarts address reception. Neither writes a partially received word.
- R11: The register index is the pointer modulo the bank depth, which is 16 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad, asynchronous |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; when 0, SDA is released |
| id_sel | input | 1 | Strap that chooses the device address (0: 0x34, 1: 0x36) |
| wr_only | input | 1 | Strap that refuses read requests when 1 |

## Verification
Single-word writes and reads separate the pointer bytes from the data bytes. Multi-word bursts show that the pointer advances once per word and not once per byte. A following read with no pointer bytes shows where the previous burst left the pointer. Addresses that belong to the other strap value, and read requests with `wr_only` set, show that a refused slave stays silent for the whole transfer. A stop after a lone data high byte, and a start in the middle of a byte, separate aborts that discard data from the restart that must still accept the next transfer. A pointer beyond the bank depth shows that the index wraps.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int unsigned RB_DW = 16;   // register word width
    localparam int unsigned RB_PW = 16;   // register pointer width

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_ACK_OUT,
        ST_SEND,
        ST_ACK_IN,
        ST_SEND_NEXT
    } rb_state_e;

    // which byte of the transfer is being received
    typedef enum logic [2:0] {
        BK_DEV,
        BK_PTR_HI,
        BK_PTR_LO,
        BK_DAT_HI,
        BK_DAT_LO
    } rb_kind_e;

endpackage

// File: rtl/i2c_rb_sync.sv
module i2c_rb_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_prev <= scl_pipe[STAGES-1];
            sda_prev <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [IW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave
    import i2c_rb_pkg::*;
#(
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ID_LO   = 7'h34,
    parameter logic [6:0]  DEV_ID_HI   = 7'h36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe,
    input  logic id_sel,
    input  logic wr_only
);

    localparam int unsigned IW = $clog2(DEPTH);

    logic sda_s, scl_rise, scl_fall, start_det, stop_det;

    rb_state_e         state_q, state_d;
    rb_kind_e          kind_q, kind_d;
    logic [3:0]        bitcnt_q, bitcnt_d;
    logic [7:0]        rx_sh_q, rx_sh_d;
    logic [7:0]        tx_sh_q, tx_sh_d;
    logic [7:0]        hold_q, hold_d;
    logic [RB_PW-1:0]  ptr_q, ptr_d;
    logic              rd_mode_q, rd_mode_d;
    logic              lo_half_q, lo_half_d;
    logic              oe_q, oe_d;

    logic              we;
    logic [RB_DW-1:0]  wdata;
    logic [RB_DW-1:0]  rdata;
    logic [7:0]        next_byte;
    logic              dev_hit;

    i2c_rb_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_rb_regfile #(.DW(RB_DW), .DEPTH(DEPTH)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .waddr (ptr_q[IW-1:0]),
        .wdata (wdata),
        .raddr (ptr_q[IW-1:0]),
        .rdata (rdata)
    );

    assign dev_hit   = (rx_sh_q[7:1] == (id_sel ? DEV_ID_HI : DEV_ID_LO));
    assign next_byte = lo_half_q ? rdata[7:0] : rdata[15:8];
    assign wdata     = {hold_q, rx_sh_q};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            kind_q    <= BK_DEV;
            bitcnt_q  <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            hold_q    <= '0;
            ptr_q     <= '0;
            rd_mode_q <= 1'b0;
            lo_half_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            kind_q    <= kind_d;
            bitcnt_q  <= bitcnt_d;
            rx_sh_q   <= rx_sh_d;
            tx_sh_q   <= tx_sh_d;
            hold_q    <= hold_d;
            ptr_q     <= ptr_d;
            rd_mode_q <= rd_mode_d;
            lo_half_q <= lo_half_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) oe_q <= 1'b0;
        else        oe_q <= oe_d;
    end

    assign sda_oe = oe_q;

    // next state and datapath
    always_comb begin
        state_d   = state_q;
        kind_d    = kind_q;
        bitcnt_d  = bitcnt_q;
        rx_sh_d   = rx_sh_q;
        tx_sh_d   = tx_sh_q;
        hold_d    = hold_q;
        ptr_d     = ptr_q;
        rd_mode_d = rd_mode_q;
        lo_half_d = lo_half_q;
        oe_d      = oe_q;
        we        = 1'b0;

        if (stop_det) begin
            state_d = ST_IDLE;
            oe_d    = 1'b0;
        end else if (start_det) begin
            state_d  = ST_RECV;
            kind_d   = BK_DEV;
            bitcnt_d = '0;
            oe_d     = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                end
                ST_RECV: begin
                    if (scl_rise && bitcnt_q != 4'd8) begin
                        rx_sh_d  = {rx_sh_q[6:0], sda_s};
                        bitcnt_d = bitcnt_q + 4'd1;
                    end else if (scl_fall && bitcnt_q == 4'd8) begin
                        state_d = ST_ACK_OUT;
                        oe_d    = 1'b1;
                        case (kind_q)
                            BK_DEV: begin
                                if (dev_hit && !(rx_sh_q[0] && wr_only)) begin
                                    rd_mode_d = rx_sh_q[0];
                                    kind_d    = BK_PTR_HI;
                                end else begin
                                    state_d = ST_IDLE;
                                    oe_d    = 1'b0;
                                end
                            end
                            BK_PTR_HI: begin
                                ptr_d[15:8] = rx_sh_q;
                                kind_d      = BK_PTR_LO;
                            end
                            BK_PTR_LO: begin
                                ptr_d[7:0] = rx_sh_q;
                                kind_d     = BK_DAT_HI;
                            end
                            BK_DAT_HI: begin
                                hold_d = rx_sh_q;
                                kind_d = BK_DAT_LO;
                            end
                            BK_DAT_LO: begin
                                we     = 1'b1;
                                ptr_d  = ptr_q + 16'd1;
                                kind_d = BK_DAT_HI;
                            end
                            default: begin
                                state_d = ST_IDLE;
                                oe_d    = 1'b0;
                            end
                        endcase
                    end
                end
                ST_ACK_OUT: begin
                    if (scl_fall) begin
                        bitcnt_d = '0;
                        if (rd_mode_q) begin
                            state_d   = ST_SEND;
                            lo_half_d = 1'b0;
                            oe_d      = ~rdata[15];
                            tx_sh_d   = {rdata[14:8], 1'b0};
                        end else begin
                            state_d = ST_RECV;
                            oe_d    = 1'b0;
                        end
                    end
                end
                ST_SEND: begin
                    if (scl_rise) begin
                        bitcnt_d = bitcnt_q + 4'd1;
                    end else if (scl_fall) begin
                        if (bitcnt_q == 4'd8) begin
                            state_d   = ST_ACK_IN;
                            oe_d      = 1'b0;
                            lo_half_d = ~lo_half_q;
                            if (lo_half_q) ptr_d = ptr_q + 16'd1;
                        end else begin
                            oe_d    = ~tx_sh_q[7];
                            tx_sh_d = {tx_sh_q[6:0], 1'b0};
                        end
                    end
                end
                ST_ACK_IN: begin
                    if (scl_rise) state_d = sda_s ? ST_IDLE : ST_SEND_NEXT;
                end
                ST_SEND_NEXT: begin
                    if (scl_fall) begin
                        state_d  = ST_SEND;
                        bitcnt_d = '0;
                        oe_d     = ~next_byte[7];
                        tx_sh_d  = {next_byte[6:0], 1'b0};
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                    oe_d    = 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/i2c_regbank_slave_chk.sv
module i2c_regbank_slave_chk
    import i2c_rb_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       scl_fall,
    input logic       stop_det,
    input rb_state_e  state,
    input logic [3:0] bitcnt
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe);  // R4

    AST_ACK_HELD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACK_OUT) |-> sda_oe);  // R3

    AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe) |-> $past(scl_fall));  // R2

    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));  // R10

    AST_BYTE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        bitcnt <= 4'd8);  // R6

endmodule

bind i2c_regbank_slave i2c_regbank_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_oe   (sda_oe),
    .scl_fall (scl_fall),
    .stop_det (stop_det),
    .state    (state_q),
    .bitcnt   (bitcnt_q)
);

// File: tb/i2c_regbank_slave_test.sv
module i2c_regbank_slave_test;

    localparam int CLK_PERIOD = 10;
    localparam int Q          = 8;   // system clocks per quarter bus bit

    logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_rel = 1'b1;
    logic id_sel = 1'b0, wr_only = 1'b0;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = m_rel & ~sda_oe;   // wired-AND with pull-up

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_regbank_slave uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl),
        .sda_i   (sda_bus),
        .sda_oe  (sda_oe),
        .id_sel  (id_sel),
        .wr_only (wr_only)
    );

    typedef struct { int val; string tag; } exp_t;
    exp_t exp_q[$];
    int   obs_q[$];
    int   checks = 0, errors = 0, r2_viol = 0, scl_hi = 0;
    bit   done = 1'b0;
    logic prev_oe = 1'b0;

    // scoreboard monitor
    initial begin
        int   o;
        exp_t e;
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0) begin
                o = obs_q.pop_front();
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL unexpected item: actual %0h expected none", o);
                end else begin
                    e = exp_q.pop_front();
                    if (o != e.val) begin
                        errors++;
                        $display("FAIL %s: actual %0h expected %0h", e.tag, o, e.val);
                    end
                end
            end
        end
    end

    // R2: SDA drive must stay put while SCL is settled high
    always @(negedge clk) begin
        if (scl) scl_hi <= scl_hi + 1; else scl_hi <= 0;
        if (rst_n && scl && scl_hi >= 4 && sda_oe != prev_oe) r2_viol <= r2_viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic expect_v(input int v, input string tag);
        exp_q.push_back('{v, tag});
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_xfer(input bit b, output bit s);
        wq(); m_rel = b;
        wq(); scl = 1'b1;
        wq(); s = sda_bus;
        wq(); scl = 1'b0;
    endtask

    task automatic start_c();
        wq(); m_rel = 1'b1;
        wq(); scl = 1'b1;
        wq(); m_rel = 1'b0;
        wq(); scl = 1'b0;
    endtask

    task automatic stop_c();
        wq(); m_rel = 1'b0;
        wq(); scl = 1'b1;
        wq(); m_rel = 1'b1;
        wq();
    endtask

    task automatic wrb(input logic [7:0] b);
        bit s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], s);
        bit_xfer(1'b1, s);
        obs_q.push_back(s ? 0 : 1);
    endtask

    task automatic rdb(input bit mack);
        logic [7:0] v;
        bit s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        bit_xfer(!mack, s);
        obs_q.push_back(int'(v));
    endtask

    task automatic wr_words(input logic [7:0] dev, input logic [15:0] a,
                            input logic [15:0] w [4], input int n, input string tag);
        start_c();
        expect_v(1, "R3"); wrb(dev);
        expect_v(1, tag);  wrb(a[15:8]);
        expect_v(1, tag);  wrb(a[7:0]);
        for (int i = 0; i < n; i++) begin
            expect_v(1, tag); wrb(w[i][15:8]);
            expect_v(1, tag); wrb(w[i][7:0]);
        end
        stop_c();
    endtask

    task automatic rd_cont(input logic [7:0] dev, input logic [15:0] w [4],
                           input int n, input string tag);
        start_c();
        expect_v(1, "R3"); wrb(dev | 8'h01);
        for (int i = 0; i < n; i++) begin
            expect_v(int'(w[i][15:8]), tag); rdb(1'b1);
            expect_v(int'(w[i][7:0]), tag);  rdb(i != n - 1);
        end
        stop_c();
    endtask

    task automatic rd_words(input logic [7:0] dev, input logic [15:0] a,
                            input logic [15:0] w [4], input int n, input string tag);
        start_c();
        expect_v(1, "R3"); wrb(dev);
        expect_v(1, tag);  wrb(a[15:8]);
        expect_v(1, tag);  wrb(a[7:0]);
        rd_cont(dev, w, n, tag);   // repeated start, no stop between
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w [4];
        bit s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R1: released after reset, pointer 0, registers zero
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);
        w = '{16'h0000, 16'h0000, 16'h0000, 16'h0000};
        rd_cont(8'h68, w, 2, "R1");

        // R6: single word write
        w = '{16'hA55A, 16'h0, 16'h0, 16'h0};
        wr_words(8'h68, 16'h0003, w, 1, "R6");

        // R7: burst write to 5..8
        w = '{16'h1111, 16'h2222, 16'h3333, 16'h4444};
        wr_words(8'h68, 16'h0005, w, 4, "R7");

        // R8: random read of register 3
        w = '{16'hA55A, 16'h0, 16'h0, 16'h0};
        rd_words(8'h68, 16'h0003, w, 1, "R8");

        // R9: burst read 5..7, then pointer sits at 8
        w = '{16'h1111, 16'h2222, 16'h3333, 16'h0};
        rd_words(8'h68, 16'h0005, w, 3, "R9");
        w = '{16'h4444, 16'h0, 16'h0, 16'h0};
        rd_cont(8'h68, w, 1, "R9");

        // R4: other address is ignored for the whole transfer
        start_c();
        expect_v(0, "R4"); wrb(8'h6C);
        expect_v(0, "R4"); wrb(8'h00);
        expect_v(0, "R4"); wrb(8'h03);
        expect_v(0, "R4"); wrb(8'hFF);
        expect_v(0, "R4"); wrb(8'hFF);
        stop_c();
        w = '{16'hA55A, 16'h0, 16'h0, 16'h0};
        rd_words(8'h68, 16'h0003, w, 1, "R4");

        // R11 with R3 strap high: pointer 0x0010 maps to register 0
        id_sel = 1'b1;
        w = '{16'hBEEF, 16'h0, 16'h0, 16'h0};
        wr_words(8'h6C, 16'h0010, w, 1, "R11");
        rd_words(8'h6C, 16'h0000, w, 1, "R11");

        // R5: read refused when write-only
        wr_only = 1'b1;
        start_c();
        expect_v(0, "R5");     wrb(8'h6D);
        expect_v(8'hFF, "R5"); rdb(1'b0);
        stop_c();
        wr_only = 1'b0;

        // R10: stop after a lone data high byte writes nothing
        start_c();
        expect_v(1, "R10"); wrb(8'h6C);
        expect_v(1, "R10"); wrb(8'h00);
        expect_v(1, "R10"); wrb(8'h01);
        expect_v(1, "R10"); wrb(8'h77);
        stop_c();
        w = '{16'h0000, 16'h0, 16'h0, 16'h0};
        rd_words(8'h6C, 16'h0001, w, 1, "R10");

        // R10: start in the middle of a byte restarts cleanly
        start_c();
        expect_v(1, "R10"); wrb(8'h6C);
        expect_v(1, "R10"); wrb(8'h00);
        expect_v(1, "R10"); wrb(8'h01);
        expect_v(1, "R10"); wrb(8'h99);
        bit_xfer(1'b1, s); bit_xfer(1'b0, s); bit_xfer(1'b1, s);
        w = '{16'h1234, 16'h0, 16'h0, 16'h0};
        wr_words(8'h6C, 16'h0001, w, 1, "R10");
        rd_words(8'h6C, 16'h0001, w, 1, "R10");

        repeat (8) @(negedge clk);
        chk(r2_viol == 0, "R2", r2_viol, 0);
        chk(exp_q.size() == 0, "R6", exp_q.size(), 0);
        chk(sda_oe == 1'b0, "R2", sda_oe, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule